// File: doc/BRIEF.md
# Clock Ratio Detector and Sync Monitor

This block sits in the system-clock domain of a stereo audio converter and watches the word clock (the left/right frame strobe). In slave mode it measures the number of system-clock cycles between rising edges of the word clock. It classifies that count as one of four ratios: 256, 384, 512 or 768 times the sample rate. From the chosen ratio it produces a clock enable that fires exactly 256 times per frame, which paces the internal datapath. In master mode the ratio comes straight from the mode pins and no measurement is used.

Once locked in slave mode, the block compares every new frame length with the nominal length of the locked ratio. The deviation is counted in system-clock cycles and weighed in bit-clock units: the ratio divided by 64 cycles per bit clock in 64-bit framing, and the ratio divided by 48 in 48-bit framing. A deviation that is too large drops the lock, stops the enable and mutes the sample data to the bipolar-zero code. Lock is regained only after two consecutive frames agree on a ratio. Data then stays muted for a further fixed number of frames before normal samples may pass.

Top module: `clkratio_sync_mon`

## Requirements
- R1: In slave mode (`mode`=00), a frame length within ±2 cycles of 256, 384, 512 or 768 is classified as ratio code 0, 1, 2 or 3 respectively. A length outside every window never produces lock, and `ratio_code` keeps its previous value.
- R2: In master mode (`mode`≠00), `ratio_code` follows the pins regardless of frame length: 01 gives code 2 (512), 10 gives code 1 (384) and 11 gives code 0 (256). `locked` is 1 and `mute` is 0. Code 3 (768) is never reported in master mode.
- R3: `ce256` is high on exactly 256 cycles of each nominal frame at every ratio, with its phase restarted at each word-clock rising edge. At code 0 it is high every cycle, at code 1 on two of every three cycles, at code 2 on every other cycle, and at code 3 on one of every three cycles.
- R4: While locked with 64-bit framing (`frame48`=0), a frame whose length differs from the nominal length by more than 6×ratio/64 cycles clears `locked` at the next rising edge. With 48-bit framing (`frame48`=1), the bound is 5×ratio/48 cycles. While unlocked in slave mode, `ce256` stays low.
- R5: A deviation at or below these bounds leaves the lock in place. For ratio 256 this means 24 cycles with 64-bit framing and 26 cycles with 48-bit framing.
- R6: In slave mode, `mute` is 1 whenever `locked` is 0. After lock is gained, `mute` stays 1 through the next 31 rising edges of the word clock and drops at the 32nd.
- R7: Lock, whether first or with a changed ratio, is taken only when two consecutive measured frames classify as the same ratio. The first rising edge after reset only starts measurement. `ratio_code` changes only when lock is taken.
- R8: During reset in slave mode, `locked`=0, `mute`=1, `ce256`=0 and `ratio_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrck | input | 1 | Word clock, synchronous to `clk` |
| frame48 | input | 1 | 1: 48 bit clocks per frame, 0: 64 |
| mode | input | 2 | 00 slave; 01/10/11 master at 512/384/256 |
| ratio_code | output | 2 | 0..3 for 256/384/512/768 |
| ce256 | output | 1 | Clock enable at 256 times the sample rate |
| locked | output | 1 | Ratio known and in sync |
| mute | output | 1 | Force sample data to bipolar zero |

## Verification
The assertions take for granted that the word clock is already synchronous to `clk`. They also assume that `mode` and `frame48` change only while reset is held, so mode-dependent properties never straddle a configuration change. The stimulus therefore drives `lrck` only at falling clock edges and sets the configuration before releasing reset. It builds each frame as a whole number of system-clock cycles, so a drift is exactly one longer or shorter frame.

// File: rtl/ckr_pkg.sv
package ckr_pkg;
   typedef enum logic [1:0] {
      RT_256 = 2'd0,
      RT_384 = 2'd1,
      RT_512 = 2'd2,
      RT_768 = 2'd3
   } ratio_t;

   localparam int NUM_RATIOS = 4;

   function automatic logic [9:0] ratio_cycles(input ratio_t r);
      case (r)
         RT_256:  return 10'd256;
         RT_384:  return 10'd384;
         RT_512:  return 10'd512;
         default: return 10'd768;
      endcase
   endfunction

   function automatic ratio_t pins_to_ratio(input logic [1:0] m);
      case (m)
         2'b01:   return RT_512;
         2'b10:   return RT_384;
         default: return RT_256;
      endcase
   endfunction
endpackage

// File: rtl/ckr_period_meter.sv
module ckr_period_meter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lrck,
   output logic             rise,
   output logic             meas_valid,
   output logic [CNT_W-1:0] period
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             lrck_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   assign rise       = lrck & ~lrck_q;
   assign meas_valid = rise & armed_q;
   assign period     = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lrck_q  <= 1'b0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         lrck_q <= lrck;
         if (rise) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/ckr_lock_tracker.sv
module ckr_lock_tracker
   import ckr_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int TOL         = 2,
   parameter int HOLD_FRAMES = 32,
   parameter int LOSE64      = 6,
   parameter int LOSE48      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meas_valid,
   input  logic             frame48,
   input  logic [CNT_W-1:0] period,
   output ratio_t           ratio,
   output logic             locked,
   output logic             hold_busy
);
   localparam int HOLD_W = $clog2(HOLD_FRAMES + 1);
   localparam int PROD_W = CNT_W + 8;

   logic [NUM_RATIOS-1:0] hit;
   ratio_t                cls_code;
   logic                  cls_valid;

   for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_cls
      localparam int NOM = (i == 3) ? 768 : 256 + 128 * i;
      localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
      localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
      assign hit[i] = (period >= LO) && (period <= HI);
   end

   always_comb begin
      cls_code = RT_256;
      for (int i = 0; i < NUM_RATIOS; i++) begin
         if (hit[i]) cls_code = ratio_t'(i[1:0]);
      end
   end
   assign cls_valid = |hit;

   ratio_t            ratio_q, cand_q;
   logic              locked_q, cand_ok_q;
   logic [HOLD_W-1:0] hold_q;

   logic [CNT_W-1:0]  nom_now, absd;
   logic [PROD_W-1:0] dev_scaled, bound_scaled;
   logic              too_far;

   always_comb begin
      nom_now = CNT_W'(ratio_cycles(ratio_q));
      absd    = (period >= nom_now) ? period - nom_now : nom_now - period;
      if (frame48) begin
         dev_scaled   = PROD_W'(absd) * PROD_W'(48);
         bound_scaled = PROD_W'(nom_now) * PROD_W'(LOSE48);
      end else begin
         dev_scaled   = PROD_W'(absd) * PROD_W'(64);
         bound_scaled = PROD_W'(nom_now) * PROD_W'(LOSE64);
      end
      too_far = dev_scaled > bound_scaled;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q   <= RT_256;
         cand_q    <= RT_256;
         cand_ok_q <= 1'b0;
         locked_q  <= 1'b0;
         hold_q    <= '0;
      end else if (meas_valid) begin
         if (locked_q) begin
            cand_ok_q <= 1'b0;
            if (too_far) begin
               locked_q <= 1'b0;
            end else if (hold_q != '0) begin
               hold_q <= hold_q - HOLD_W'(1);
            end
         end else begin
            cand_q    <= cls_code;
            cand_ok_q <= cls_valid;
            if (cls_valid && cand_ok_q && (cand_q == cls_code)) begin
               locked_q <= 1'b1;
               ratio_q  <= cls_code;
               hold_q   <= HOLD_W'(HOLD_FRAMES);
            end
         end
      end
   end

   assign ratio     = ratio_q;
   assign locked    = locked_q;
   assign hold_busy = (hold_q != '0);
endmodule

// File: rtl/ckr_ce_divider.sv
module ckr_ce_divider
   import ckr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   rise,
   input  ratio_t ratio,
   output logic   ce
);
   logic [1:0] ph_q, ph_eff, ph_nxt;

   always_comb begin
      ph_eff = rise ? 2'd0 : ph_q;
      case (ratio)
         RT_256: begin
            ce     = 1'b1;
            ph_nxt = 2'd0;
         end
         RT_384: begin
            ce     = (ph_eff != 2'd2);
            ph_nxt = (ph_eff >= 2'd2) ? 2'd0 : ph_eff + 2'd1;
         end
         RT_512: begin
            ce     = (ph_eff == 2'd0);
            ph_nxt = (ph_eff == 2'd0) ? 2'd1 : 2'd0;
         end
         default: begin
            ce     = (ph_eff == 2'd0);
            ph_nxt = (ph_eff >= 2'd2) ? 2'd0 : ph_eff + 2'd1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 2'd0;
      else        ph_q <= ph_nxt;
   end
endmodule

// File: rtl/clkratio_sync_mon.sv
module clkratio_sync_mon
   import ckr_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int TOL         = 2,
   parameter int HOLD_FRAMES = 32,
   parameter int LOSE64      = 6,
   parameter int LOSE48      = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lrck,
   input  logic       frame48,
   input  logic [1:0] mode,
   output logic [1:0] ratio_code,
   output logic       ce256,
   output logic       locked,
   output logic       mute
);
   if (CNT_W < 11) begin : g_bad_cnt
      $error("CNT_W must hold a 768-cycle frame plus drift");
   end
   if (TOL < 0 || TOL > 63) begin : g_bad_tol
      $error("TOL must keep the ratio windows apart");
   end
   if (HOLD_FRAMES < 1) begin : g_bad_hold
      $error("HOLD_FRAMES must be at least one frame");
   end
   if (LOSE64 < 1 || LOSE48 < 1) begin : g_bad_lose
      $error("loss bounds must be positive");
   end

   logic             rise, meas_valid, trk_locked, hold_busy, div_ce, master;
   logic [CNT_W-1:0] period;
   ratio_t           trk_ratio, eff_ratio;

   assign master    = (mode != 2'b00);
   assign eff_ratio = master ? pins_to_ratio(mode) : trk_ratio;

   ckr_period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .lrck(lrck),
      .rise(rise), .meas_valid(meas_valid), .period(period)
   );

   ckr_lock_tracker #(
      .CNT_W(CNT_W), .TOL(TOL), .HOLD_FRAMES(HOLD_FRAMES),
      .LOSE64(LOSE64), .LOSE48(LOSE48)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .frame48(frame48),
      .period(period), .ratio(trk_ratio), .locked(trk_locked), .hold_busy(hold_busy)
   );

   ckr_ce_divider u_div (
      .clk(clk), .rst_n(rst_n), .rise(rise), .ratio(eff_ratio), .ce(div_ce)
   );

   assign ratio_code = eff_ratio;
   assign locked     = master | trk_locked;
   assign ce256      = div_ce & (master | trk_locked);
   assign mute       = ~master & (~trk_locked | hold_busy);
endmodule

// File: rtl/clkratio_sync_mon_chk.sv
module clkratio_sync_mon_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic [1:0] ratio_code,
   input logic       ce256,
   input logic       locked,
   input logic       mute
);
   logic slave;
   assign slave = (mode == 2'b00);

   AST_MASTER_NO768: assert property (@(posedge clk) disable iff (!rst_n)
      !slave |-> (ratio_code != 2'd3)); // R2
   AST_MASTER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !slave |-> (locked && !mute)); // R2
   AST_UNLOCK_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (slave && !locked) |-> !ce256); // R4
   AST_UNLOCK_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      (slave && !locked) |-> mute); // R6
   AST_RELOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (slave && $rose(locked)) |-> mute); // R6
   AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (slave && $past(slave) && locked && $past(locked)) |-> $stable(ratio_code)); // R7
endmodule

bind clkratio_sync_mon clkratio_sync_mon_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .ratio_code(ratio_code),
   .ce256(ce256), .locked(locked), .mute(mute)
);

// File: tb/clkratio_sync_mon_test.sv
module clkratio_sync_mon_test;
   logic       clk = 1'b0;
   logic       rst_n, lrck, frame48;
   logic [1:0] mode;
   logic [1:0] ratio_code;
   logic       ce256, locked, mute;
   int         n_chk = 0;
   int         n_bad = 0;
   int         ce_cnt = 0;

   always #5 clk = ~clk;

   clkratio_sync_mon uut (
      .clk(clk), .rst_n(rst_n), .lrck(lrck), .frame48(frame48), .mode(mode),
      .ratio_code(ratio_code), .ce256(ce256), .locked(locked), .mute(mute)
   );

   // fields: mode[27:26] frame48[25] len[24:14] code[13:12] locked[11] ce_per_frame[10:0]
   localparam logic [27:0] VECS [13] = '{
      {2'd0, 1'b0, 11'd256, 2'd0, 1'b1, 11'd256},  // R1 R3 slave 256
      {2'd0, 1'b0, 11'd384, 2'd1, 1'b1, 11'd256},  // R1 R3 slave 384
      {2'd0, 1'b0, 11'd512, 2'd2, 1'b1, 11'd256},  // R1 R3 slave 512
      {2'd0, 1'b0, 11'd768, 2'd3, 1'b1, 11'd256},  // R1 R3 slave 768
      {2'd0, 1'b0, 11'd258, 2'd0, 1'b1, 11'd258},  // R1 upper tolerance
      {2'd0, 1'b0, 11'd254, 2'd0, 1'b1, 11'd254},  // R1 lower tolerance
      {2'd0, 1'b0, 11'd259, 2'd0, 1'b0, 11'd0},    // R1 outside window
      {2'd0, 1'b1, 11'd768, 2'd3, 1'b1, 11'd256},  // R1 48-bit framing
      {2'd3, 1'b0, 11'd256, 2'd0, 1'b1, 11'd256},  // R2 master 256
      {2'd2, 1'b0, 11'd384, 2'd1, 1'b1, 11'd256},  // R2 master 384
      {2'd1, 1'b0, 11'd512, 2'd2, 1'b1, 11'd256},  // R2 master 512
      {2'd1, 1'b0, 11'd384, 2'd2, 1'b1, 11'd192},  // R2 pins win over frames
      {2'd3, 1'b0, 11'd768, 2'd0, 1'b1, 11'd768}   // R2 no 768 in master
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input logic l);
      @(negedge clk);
      lrck = l;
      #4;
      if (ce256) ce_cnt++;
   endtask

   task automatic frame(input int len);
      ce_cnt = 0;
      for (int i = 0; i < len; i++) tick(i < len / 2);
   endtask

   task automatic frames(input int n, input int len);
      for (int k = 0; k < n; k++) frame(len);
   endtask

   task automatic do_reset(input logic [1:0] m, input logic f48);
      rst_n = 1'b0; lrck = 1'b0; mode = m; frame48 = f48;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1_500_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R8 reset state
      rst_n = 1'b0; lrck = 1'b0; mode = 2'b00; frame48 = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      check("R8", "locked in reset", int'(locked), 0);
      check("R8", "mute in reset", int'(mute), 1);
      check("R8", "ce256 in reset", int'(ce256), 0);
      check("R8", "ratio_code in reset", int'(ratio_code), 0);

      // table walk: four frames each, last frame's enables counted
      for (int v = 0; v < 13; v++) begin
         do_reset(VECS[v][27:26], VECS[v][25]);
         frames(4, int'(VECS[v][24:14]));
         check("R1/R2", $sformatf("vec %0d ratio_code", v), int'(ratio_code), int'(VECS[v][13:12]));
         check("R1/R2", $sformatf("vec %0d locked", v), int'(locked), int'(VECS[v][11]));
         check("R3", $sformatf("vec %0d ce per frame", v), ce_cnt, int'(VECS[v][10:0]));
      end

      // R7 first lock needs two measured frames; R6 hold of 32 edges
      do_reset(2'b00, 1'b0);
      frames(2, 256);
      check("R7", "unlocked after two frames", int'(locked), 0);
      frame(256);
      check("R7", "locked after three frames", int'(locked), 1);
      check("R6", "muted right after lock", int'(mute), 1);
      frames(31, 256);
      check("R6", "still muted after 31 edges", int'(mute), 1);
      frame(256);
      check("R6", "unmuted at 32nd edge", int'(mute), 0);

      // R5 drift at the bound keeps lock (64-bit framing, 24 cycles)
      frame(280); frame(256);
      check("R5", "+24 drift keeps lock", int'(locked), 1);
      check("R5", "+24 drift keeps data", int'(mute), 0);
      frame(232); frame(256);
      check("R5", "-24 drift keeps lock", int'(locked), 1);

      // R4 drift past bound drops lock, halts enable
      frame(281); frame(256);
      check("R4", "+25 drift drops lock", int'(locked), 0);
      check("R6", "mute after loss", int'(mute), 1);
      frame(256);
      check("R4", "no ce while unlocked", ce_cnt, 0);
      frame(256);
      check("R6", "relocked", int'(locked), 1);
      check("R6", "muted after relock", int'(mute), 1);
      frames(32, 256);
      check("R6", "unmuted 32 edges after relock", int'(mute), 0);

      // R7 ratio change needs two agreeing frames
      frames(3, 512);
      check("R7", "one 512 measurement not enough", int'(locked), 0);
      check("R7", "code held while unlocked", int'(ratio_code), 0);
      frame(512);
      check("R7", "locked on 512", int'(locked), 1);
      check("R1", "code for 512", int'(ratio_code), 2);
      frame(512);
      check("R3", "ce per 512 frame", ce_cnt, 256);

      // R5 / R4 in 48-bit framing (bound 26 cycles at 256)
      do_reset(2'b00, 1'b1);
      frames(3, 256);
      frame(282); frame(256);
      check("R5", "48-bit +26 keeps lock", int'(locked), 1);
      frame(283); frame(256);
      check("R4", "48-bit +27 drops lock", int'(locked), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule